// File: doc/BRIEF.md
# Sideband-Triggered Low-Power Gating Controller

This block lets a streaming datapath drop into a low-power state on a regular schedule, with no software action from one sleep period to the next. One bit of the user sideband field of the band-0 input stream acts as the trigger. A small configuration port chooses the trigger mode, which sideband bit to watch, and whether the state is active while that bit is low or while it is high. Once the continuous mode is armed, every change of the watched bit moves the block into or out of the low-power state on its own.

While the block is asleep, the data output stays frozen at its last value and its valid flag stays low. The `lowPower` status doubles as the disable for the datapath. Every capture channel, across all bands at once, is forced to stop at the moment of entry, and a one-cycle pulse flags each channel that was cut short. New capture starts are refused until the block wakes. The control tracking keeps running through the whole period: a sequence position that advances on every input beat and a frame position that advances on every clock. Entry and exit each take effect two clock edges after the sideband beat that causes them.

Top module: `sleep_gate`

## Requirements
- R1: With mode code 2 (continuous), the block enters the low-power state whenever the selected bit equals the polarity setting, and leaves it whenever the bit differs. This repeats for any number of periods without a new configuration write.
- R2: `cfgBitSel` chooses which bit of `inUser` serves as the trigger; no other bit of `inUser` has any influence.
- R3: With `cfgPolarity` = 0 the state is active while the selected bit is 0; with `cfgPolarity` = 1 it is active while the bit is 1.
- R4: Entry latency: when a valid beat that meets the trigger condition is sampled at rising edge N, `lowPower` first reads 1 after edge N+1.
- R5: Exit latency: when a valid beat that no longer meets the condition is sampled at edge N, `lowPower` first reads 0 after edge N+1.
- R6: When `lowPower` is 1 during a cycle, the next edge leaves `outData` unchanged and drives `outValid` to 0. When `lowPower` is 0, each valid beat's `inData` appears on `outData` with `outValid` = 1 one edge later.
- R7: `seqPos` counts valid beats modulo SEQ_LEN and `framePos` counts clock edges modulo FRAME_LEN. Both keep counting regardless of `lowPower`.
- R8: On the edge where `lowPower` rises, every active capture channel is cleared. For exactly the one following cycle, `capAbort` shows a 1 for each channel that was cleared.
- R9: `capStart` (one bit per channel) sets that channel's `capActive` on the next edge, except while `lowPower` is 1 or on the entry edge, where it is ignored. After exit, a start takes effect on the edge where it is presented. A start wins over `capStop` for the same channel in the same cycle.
- R10: Any mode code other than 2 (0 = disabled, 1 and 3 = treated as disabled) prevents entry whatever the sideband bit does. A valid beat seen under such a mode brings the block out of the low-power state.
- R11: A configuration write is held aside and applies from the next valid beat onward. The trigger bit is sampled only on cycles with `inValid` = 1, and between beats the trigger state is held.
- R12: During and just after reset, `lowPower`, `outValid`, `capActive`, `capAbort`, `seqPos` and `framePos` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Trigger mode (2 = continuous, other codes disabled) |
| cfgBitSel | input | $clog2(USER_W) | Index of the trigger bit within `inUser` |
| cfgPolarity | input | 1 | Bit value that means low power |
| inValid | input | 1 | Band-0 input beat valid |
| inUser | input | USER_W | Band-0 user sideband field |
| inData | input | DATA_W | Band-0 input data |
| capStart | input | NUM_CAP | Per-channel scheduled capture start |
| capStop | input | NUM_CAP | Per-channel capture end |
| outValid | output | 1 | Output beat valid |
| outData | output | DATA_W | Output data, frozen in low power |
| lowPower | output | 1 | Low-power status and datapath disable |
| capActive | output | NUM_CAP | Capture window running, per channel |
| capAbort | output | NUM_CAP | One-cycle pulse per capture cut short at entry |
| seqPos | output | $clog2(SEQ_LEN) | Sequence position, counts valid beats |
| framePos | output | $clog2(FRAME_LEN) | Frame position, counts clocks |

## Verification
The trigger is tried with the watched bit toggling low and high several times under one configuration, which shows that the trigger re-arms by itself and that both latencies are two edges. A second bit with the opposite polarity is then driven so that the old and the new configuration would give different answers, which shows that the bit index and polarity are honoured and that a write waits for the next beat. Runs of the matching bit value with `inValid` low separate beat-only sampling from level sensing. Disabled mode codes are tried while the block is asleep, to show that they force an exit. A scoreboard follows every data beat through the sleep periods, and captures that are running, stopping, starting during sleep and starting after wake-up tell abort, refusal and normal start apart.

// File: rtl/sleep_gate_pkg.sv
package sleep_gate_pkg;
  // Trigger mode codes
  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_CONT = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic sleeping;  // datapath disabled, outputs held
    logic enter;     // this edge moves into the low-power state
  } gateStrobe_t;
endpackage

// File: rtl/sleep_gate_ctrl.sv
module sleep_gate_ctrl
  import sleep_gate_pkg::*;
#(
  parameter int USER_W    = 8,
  parameter int SEQ_LEN   = 12,
  parameter int FRAME_LEN = 1000,
  localparam int BIT_W    = $clog2(USER_W),
  localparam int SEQ_W    = $clog2(SEQ_LEN),
  localparam int FRM_W    = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgMode,
  input  logic [BIT_W-1:0]  cfgBitSel,
  input  logic              cfgPolarity,
  input  logic              inValid,
  input  logic [USER_W-1:0] inUser,
  output gateStrobe_t       strobe,
  output logic              lowPower,
  output logic [SEQ_W-1:0]  seqPos,
  output logic [FRM_W-1:0]  framePos
);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_LEN - 1);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(FRAME_LEN - 1);

  // Shadow (written) and active (beat-applied) configuration
  logic [1:0]       shMode, actMode, effMode;
  logic [BIT_W-1:0] shBit, actBit, effBit;
  logic             shPol, actPol, effPol;
  logic             pending;
  logic             hit;
  logic             trigLvl;  // first latency stage, updated on beats only
  logic             sleepQ;   // second latency stage, the state itself

  always_comb begin
    effMode = pending ? shMode : actMode;
    effBit  = pending ? shBit  : actBit;
    effPol  = pending ? shPol  : actPol;
    hit     = (effMode == MODE_CONT) && (inUser[effBit] == effPol);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shMode  <= MODE_OFF;
      shBit   <= '0;
      shPol   <= 1'b0;
      actMode <= MODE_OFF;
      actBit  <= '0;
      actPol  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (inValid) begin
        actMode <= effMode;
        actBit  <= effBit;
        actPol  <= effPol;
      end
      if (cfgWrEn) begin
        shMode  <= cfgMode;
        shBit   <= cfgBitSel;
        shPol   <= cfgPolarity;
        pending <= 1'b1;
      end else if (inValid) begin
        pending <= 1'b0;
      end
    end
  end

  // Two-edge entry/exit pipeline
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trigLvl <= 1'b0;
      sleepQ  <= 1'b0;
    end else begin
      if (inValid) trigLvl <= hit;
      sleepQ <= trigLvl;
    end
  end

  // Tracking counters run regardless of the low-power state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seqPos   <= '0;
      framePos <= '0;
    end else begin
      if (inValid) seqPos <= (seqPos == SEQ_LAST) ? '0 : seqPos + 1'b1;
      framePos <= (framePos == FRM_LAST) ? '0 : framePos + 1'b1;
    end
  end

  assign strobe.sleeping = sleepQ;
  assign strobe.enter    = trigLvl & ~sleepQ;
  assign lowPower        = sleepQ;
endmodule

// File: rtl/sleep_gate_dp.sv
module sleep_gate_dp
  import sleep_gate_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_CAP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  gateStrobe_t        strobe,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inData,
  input  logic [NUM_CAP-1:0] capStart,
  input  logic [NUM_CAP-1:0] capStop,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  output logic [NUM_CAP-1:0] capActive,
  output logic [NUM_CAP-1:0] capAbort
);
  // Data stage: frozen while sleeping
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (strobe.sleeping) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) outData <= inData;
    end
  end

  // Capture windows, one per channel
  for (genvar g = 0; g < NUM_CAP; g++) begin : gCap
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        capActive[g] <= 1'b0;
        capAbort[g]  <= 1'b0;
      end else begin
        capAbort[g] <= strobe.enter & capActive[g];
        if (strobe.enter)
          capActive[g] <= 1'b0;
        else if (capStart[g] && !strobe.sleeping)
          capActive[g] <= 1'b1;
        else if (capStop[g])
          capActive[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sleep_gate.sv
module sleep_gate
  import sleep_gate_pkg::*;
#(
  parameter int USER_W    = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_CAP   = 4,
  parameter int SEQ_LEN   = 12,
  parameter int FRAME_LEN = 1000,
  localparam int BIT_W    = $clog2(USER_W),
  localparam int SEQ_W    = $clog2(SEQ_LEN),
  localparam int FRM_W    = $clog2(FRAME_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgMode,
  input  logic [BIT_W-1:0]   cfgBitSel,
  input  logic               cfgPolarity,
  input  logic               inValid,
  input  logic [USER_W-1:0]  inUser,
  input  logic [DATA_W-1:0]  inData,
  input  logic [NUM_CAP-1:0] capStart,
  input  logic [NUM_CAP-1:0] capStop,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  output logic               lowPower,
  output logic [NUM_CAP-1:0] capActive,
  output logic [NUM_CAP-1:0] capAbort,
  output logic [SEQ_W-1:0]   seqPos,
  output logic [FRM_W-1:0]   framePos
);
  gateStrobe_t strobe;

  sleep_gate_ctrl #(
    .USER_W(USER_W), .SEQ_LEN(SEQ_LEN), .FRAME_LEN(FRAME_LEN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgWrEn(cfgWrEn), .cfgMode(cfgMode), .cfgBitSel(cfgBitSel),
    .cfgPolarity(cfgPolarity), .inValid(inValid), .inUser(inUser),
    .strobe(strobe), .lowPower(lowPower),
    .seqPos(seqPos), .framePos(framePos)
  );

  sleep_gate_dp #(
    .DATA_W(DATA_W), .NUM_CAP(NUM_CAP)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .inValid(inValid), .inData(inData),
    .capStart(capStart), .capStop(capStop),
    .outValid(outValid), .outData(outData),
    .capActive(capActive), .capAbort(capAbort)
  );
endmodule

// File: rtl/sleep_gate_chk.sv
module sleep_gate_chk #(
  parameter int DATA_W    = 16,
  parameter int NUM_CAP   = 4,
  parameter int FRAME_LEN = 1000,
  localparam int FRM_W    = $clog2(FRAME_LEN)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               outValid,
  input logic [DATA_W-1:0]  outData,
  input logic               lowPower,
  input logic [NUM_CAP-1:0] capActive,
  input logic [NUM_CAP-1:0] capAbort,
  input logic [FRM_W-1:0]   framePos
);
  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lowPower |=> $stable(outData));

  p_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lowPower |=> !outValid);

  p_frame_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> framePos == (($past(framePos) == FRM_W'(FRAME_LEN - 1)) ? '0
                          : $past(framePos) + 1'b1));

  p_entry_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowPower) |-> capActive == '0);

  p_abort_at_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (capAbort != '0) |-> $rose(lowPower));

  p_abort_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (capAbort != '0) |=> capAbort == '0);

  p_no_capture_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lowPower |-> capActive == '0);
endmodule

bind sleep_gate sleep_gate_chk #(
  .DATA_W(DATA_W), .NUM_CAP(NUM_CAP), .FRAME_LEN(FRAME_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .outValid(outValid), .outData(outData),
  .lowPower(lowPower), .capActive(capActive), .capAbort(capAbort),
  .framePos(framePos)
);

// File: tb/sleep_gate_test.sv
module sleep_gate_test;
  localparam int USER_W = 8, DATA_W = 16, NUM_CAP = 4;
  localparam int SEQ_LEN = 12, FRAME_LEN = 1000;
  localparam int BIT_W = $clog2(USER_W), SEQ_W = $clog2(SEQ_LEN), FRM_W = $clog2(FRAME_LEN);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfgWrEn = 1'b0, cfgPolarity = 1'b0, inValid = 1'b0;
  logic [1:0] cfgMode = '0;
  logic [BIT_W-1:0] cfgBitSel = '0;
  logic [USER_W-1:0] inUser = '0;
  logic [DATA_W-1:0] inData = '0;
  logic [NUM_CAP-1:0] capStart = '0, capStop = '0;
  logic outValid, lowPower;
  logic [DATA_W-1:0] outData;
  logic [NUM_CAP-1:0] capActive, capAbort;
  logic [SEQ_W-1:0] seqPos;
  logic [FRM_W-1:0] framePos;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  sleep_gate uut (.*);

  int errors = 0, checks = 0;
  bit running = 1'b0, done = 1'b0;
  logic [DATA_W-1:0] dat = 16'h1000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---- Reference model built from the requirements ----
  logic [1:0] mShMode, mActMode;
  logic [BIT_W-1:0] mShBit, mActBit;
  logic mShPol, mActPol, mPend, mTrig, mLp, mLpOld, mExpValid;
  int beatCnt, cycCnt;
  wire [1:0] mEffMode = mPend ? mShMode : mActMode;
  wire [BIT_W-1:0] mEffBit = mPend ? mShBit : mActBit;
  wire mEffPol = mPend ? mShPol : mActPol;
  wire mHit = (mEffMode == 2'd2) && (inUser[mEffBit] == mEffPol);
  logic [DATA_W-1:0] sbq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mShMode <= 0; mActMode <= 0; mShBit <= 0; mActBit <= 0;
      mShPol <= 0; mActPol <= 0; mPend <= 0; mTrig <= 0; mLp <= 0;
      mLpOld <= 0; mExpValid <= 0; beatCnt <= 0; cycCnt <= 0;
    end else begin
      cycCnt <= cycCnt + 1;
      if (inValid) begin
        mActMode <= mEffMode; mActBit <= mEffBit; mActPol <= mEffPol;
        mTrig <= mHit;
        beatCnt <= beatCnt + 1;
      end
      if (cfgWrEn) begin
        mShMode <= cfgMode; mShBit <= cfgBitSel; mShPol <= cfgPolarity; mPend <= 1'b1;
      end else if (inValid) mPend <= 1'b0;
      mLp <= mTrig;
      mLpOld <= mLp;
      mExpValid <= inValid && !mLp;
    end
  end

  // ---- Monitor: pops the scoreboard and checks tracking every cycle ----
  logic [DATA_W-1:0] prevOut = '0;
  always @(negedge clk) begin
    if (running && rst_n) begin
      check("R4 R5 lowPower timing", lowPower, mLp);
      check("R6 outValid", outValid, mExpValid);
      if (mLpOld) check("R6 data held", outData, prevOut);
      else if (mExpValid) begin
        if (sbq.size() == 0) check("R6 scoreboard empty", 1, 0);
        else check("R6 data beat", outData, sbq.pop_front());
      end
      check("R7 seqPos", seqPos, beatCnt % SEQ_LEN);
      check("R7 framePos", framePos, cycCnt % FRAME_LEN);
      prevOut = outData;
    end
  end

  // ---- Driver ----
  task automatic tick(input logic v, input logic [USER_W-1:0] u,
                      input logic [NUM_CAP-1:0] cs, input logic [NUM_CAP-1:0] ce);
    inValid = v; inUser = u; inData = dat; capStart = cs; capStop = ce;
    if (v && !mLp) sbq.push_back(dat);
    dat = dat + 16'h0013;
    @(negedge clk);
    inValid = 1'b0; capStart = '0; capStop = '0;
  endtask

  task automatic beat(input logic [USER_W-1:0] u);
    tick(1'b1, u, '0, '0);
  endtask

  task automatic cfg(input logic [1:0] m, input logic [BIT_W-1:0] b, input logic p);
    cfgWrEn = 1'b1; cfgMode = m; cfgBitSel = b; cfgPolarity = p;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 lowPower", lowPower, 0);
    check("R12 outValid", outValid, 0);
    check("R12 capActive", capActive, 0);
    check("R12 capAbort", capAbort, 0);
    check("R12 seqPos", seqPos, 0);
    check("R12 framePos", framePos, 0);
    rst_n = 1'b1;
    running = 1'b1;

    cfg(2'd2, 3'd7, 1'b0);
    repeat (3) beat(8'h80);
    tick(1'b1, 8'h80, 4'b0011, '0);
    check("R9 start while awake", capActive, 4'b0011);
    tick(1'b1, 8'h80, '0, 4'b0010);
    check("R9 stop", capActive, 4'b0001);
    tick(1'b1, 8'h80, 4'b0010, '0);
    check("R9 restart", capActive, 4'b0011);

    // Entry
    beat(8'h00);
    check("R4 one edge after trigger beat", lowPower, 0);
    beat(8'h00);
    check("R4 two edges after trigger beat", lowPower, 1);
    check("R8 captures cleared", capActive, 0);
    check("R8 abort pulse", capAbort, 4'b0011);
    beat(8'h00);
    check("R8 abort pulse one cycle", capAbort, 0);
    tick(1'b1, 8'h00, 4'b0100, '0);
    check("R9 start ignored asleep", capActive, 0);
    repeat (5) beat(8'h00);
    check("R7 seqPos asleep", seqPos, beatCnt % SEQ_LEN);

    // Exit
    beat(8'h80);
    check("R5 one edge after clear beat", lowPower, 1);
    beat(8'h80);
    check("R5 two edges after clear beat", lowPower, 0);
    tick(1'b1, 8'h80, 4'b0100, '0);
    check("R9 start after exit", capActive, 4'b0100);
    tick(1'b1, 8'h80, 4'b1000, 4'b1000);
    check("R9 start wins over stop", capActive, 4'b1100);

    // R1: repeated periods, no rewrite
    for (int k = 0; k < 2; k++) begin
      beat(8'h00); beat(8'h00);
      check("R1 re-entry", lowPower, 1);
      if (k == 0) check("R8 abort on re-entry", capAbort, 4'b1100);
      beat(8'h80); beat(8'h80);
      check("R1 re-exit", lowPower, 0);
    end

    // R11: sampling only on valid beats
    for (int k = 0; k < 4; k++) begin
      tick(1'b0, 8'h00, '0, '0);
      check("R11 no beat no entry", lowPower, 0);
    end
    beat(8'h00); beat(8'h00);
    check("R11 beat enters", lowPower, 1);
    beat(8'h80); beat(8'h80);
    check("R11 beat exits", lowPower, 0);

    // R2/R3: bit 2, polarity 1; old config would disagree
    cfg(2'd2, 3'd2, 1'b1);
    check("R11 write alone no change", lowPower, 0);
    beat(8'h84); beat(8'h84);
    check("R2 R3 new bit/polarity enters", lowPower, 1);
    beat(8'h00); beat(8'h00);
    check("R3 polarity 1 exits on 0", lowPower, 0);
    beat(8'h04); beat(8'h04);
    check("R2 bit 2 only", lowPower, 1);

    // R10: disabled modes force exit and block entry
    cfg(2'd0, 3'd2, 1'b1);
    beat(8'h04); beat(8'h04);
    check("R10 mode 0 exits", lowPower, 0);
    for (int k = 0; k < 4; k++) begin
      beat(8'h04);
      check("R10 mode 0 no entry", lowPower, 0);
    end
    cfg(2'd3, 3'd2, 1'b1);
    for (int k = 0; k < 4; k++) begin
      beat(8'h04);
      check("R10 mode 3 no entry", lowPower, 0);
    end
    cfg(2'd2, 3'd2, 1'b1);
    beat(8'h04); beat(8'h04);
    check("R1 rearmed after mode 2", lowPower, 1);
    beat(8'h00); beat(8'h00);
    check("R1 exit after rearm", lowPower, 0);

    repeat (3) tick(1'b0, 8'h00, '0, '0);
    check("R6 scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule